// File: doc/BRIEF.md
# Inter-Processor Mailbox Flag Registers

This block holds a small set of 32-bit mailbox registers that a main processor uses to talk to an I/O processor. It has three kinds of register:

- **Data words.** Plain data words are loaded directly with whatever is written to them.
- **Flag word.** One flag word is reached through two addresses. A write to the set alias ORs the written value into the flags. A write to the clear alias drops every flag bit written as one. Both aliases read back the current flag word.
- **Control word.** Bit 18 and bit 19 of the control word act on the write itself. Bit 18 sends a single-cycle interrupt pulse to the I/O processor, and bit 19 sends a single-cycle reset pulse. Bit 8 of the control word is stored.

The register port is a single-cycle write strobe with a word address and a combinational read path. Each pulse output goes high in the cycle after the clock edge that takes the control write, and stays high for one cycle.

Top module: `ipc_mailbox_regs`

## Requirements
- R1: Word addresses 0 and 1 are data words. A write loads the whole 32-bit value into the addressed word and leaves every other register unchanged. A read returns the stored value.
- R2: A write to word address 2 (set alias) makes the flag word equal to its old value OR the written value.
- R3: A write to word address 3 (clear alias) makes the flag word equal to its old value AND NOT the written value.
- R4: Reads of word address 2 and of word address 3 both return the current flag word.
- R5: A write to word address 4 (control) with bit 18 set drives iop_irq_o high for exactly the one cycle after the write edge. Any other cycle leaves it low.
- R6: A write to word address 4 with bit 19 set drives iop_rst_o high for exactly the one cycle after the write edge. Any other cycle leaves it low.
- R7: Bit 8 of the control word takes bit 8 of each control write. A read of word address 4 returns that bit in position 8 and zero in all other positions, including bits 18 and 19.
- R8: While rst_ni is low, all registers read zero, both pulses are low, and writes have no effect.
- R9: Word addresses 5 to 7 read zero, and writes to them change no register and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| iop_irq_o | output | 1 | Interrupt pulse to the I/O processor |
| iop_rst_o | output | 1 | Reset pulse to the I/O processor |

## Verification
The bench aims at the following cases and the faults they would expose:

- **Set alias with a plain store.** If the set alias stored the value instead of merging it, flag bits set earlier would be lost.
- **Clear alias read as a mask.** If the clear alias treated the value as a keep-mask, the bits written as zero would be cleared instead of the ones.
- **Pulse length.** A pulse that was level-held instead of single-cycle would still be high in the idle cycle after the write.
- **Pulse bits read back.** If bits 18 or 19 were stored, they would show up when the control word is read.
- **Reset and unmapped addresses.** The bench writes control with both trigger bits set while rst_ni is low, and writes to the unmapped addresses 5 to 7. Any leak would show as a pulse or as a changed register.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned IRQ_BIT  = 18;
  localparam int unsigned IOPR_BIT = 19;
  localparam int unsigned KEEP_BIT = 8;

  typedef struct packed {
    logic flag_set;
    logic flag_clr;
    logic ctrl;
  } mbx_strobe_t;
endpackage

// File: rtl/ipc_mbx_decode.sv
module ipc_mbx_decode #(
  parameter int unsigned NUM_DATA = 2,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  output logic [NUM_DATA-1:0]               data_we_o,
  output ipc_mailbox_pkg::mbx_strobe_t      strb_o
);
  localparam int unsigned SET_IDX  = NUM_DATA;
  localparam int unsigned CLR_IDX  = NUM_DATA + 1;
  localparam int unsigned CTRL_IDX = NUM_DATA + 2;

  for (genvar i = 0; i < NUM_DATA; i++) begin : g_we
    assign data_we_o[i] = wr_en_i && (addr_i == ADDR_W'(i));
  end

  assign strb_o.flag_set = wr_en_i && (addr_i == ADDR_W'(SET_IDX));
  assign strb_o.flag_clr = wr_en_i && (addr_i == ADDR_W'(CLR_IDX));
  assign strb_o.ctrl     = wr_en_i && (addr_i == ADDR_W'(CTRL_IDX));
endmodule

// File: rtl/ipc_mbx_flags.sv
module ipc_mbx_flags #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_we_i)      flag_d = flag_q | wdata_i;
    else if (clr_we_i) flag_d = flag_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ipc_mbx_ctrl.sv
module ipc_mbx_ctrl #(
  parameter int unsigned W        = 32,
  parameter int unsigned IRQ_BIT  = 18,
  parameter int unsigned IOPR_BIT = 19,
  parameter int unsigned KEEP_BIT = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_rd_o,
  output logic         irq_o,
  output logic         iopr_o
);
  logic keep_q, irq_q, iopr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q <= 1'b0;
      irq_q  <= 1'b0;
      iopr_q <= 1'b0;
    end else begin
      // trigger bits are self-clearing: re-evaluated every cycle
      irq_q  <= we_i && wdata_i[IRQ_BIT];
      iopr_q <= we_i && wdata_i[IOPR_BIT];
      if (we_i) keep_q <= wdata_i[KEEP_BIT];
    end
  end

  always_comb begin
    ctrl_rd_o           = '0;
    ctrl_rd_o[KEEP_BIT] = keep_q;
  end

  assign irq_o  = irq_q;
  assign iopr_o = iopr_q;
endmodule

// File: rtl/ipc_mailbox_regs.sv
module ipc_mailbox_regs #(
  parameter int unsigned NUM_DATA = 2,
  parameter int unsigned ADDR_W   = $clog2(NUM_DATA + 3)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [ipc_mailbox_pkg::WORD_W-1:0] wdata_i,
  output logic [ipc_mailbox_pkg::WORD_W-1:0] rdata_o,
  output logic                               iop_irq_o,
  output logic                               iop_rst_o
);
  import ipc_mailbox_pkg::*;

  localparam int unsigned SET_IDX  = NUM_DATA;
  localparam int unsigned CLR_IDX  = NUM_DATA + 1;
  localparam int unsigned CTRL_IDX = NUM_DATA + 2;

  logic [NUM_DATA-1:0] data_we;
  mbx_strobe_t         strb;
  logic [WORD_W-1:0]   data_q [NUM_DATA];
  logic [WORD_W-1:0]   flag_q;
  logic [WORD_W-1:0]   ctrl_rd;
  logic                ctrl_keep;

  ipc_mbx_decode #(.NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)) u_decode (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .data_we_o (data_we),
    .strb_o    (strb)
  );

  for (genvar i = 0; i < NUM_DATA; i++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         data_q[i] <= '0;
      else if (data_we[i]) data_q[i] <= wdata_i;
    end
  end

  ipc_mbx_flags #(.W(WORD_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (strb.flag_set),
    .clr_we_i (strb.flag_clr),
    .wdata_i  (wdata_i),
    .flag_o   (flag_q)
  );

  ipc_mbx_ctrl #(
    .W(WORD_W), .IRQ_BIT(IRQ_BIT), .IOPR_BIT(IOPR_BIT), .KEEP_BIT(KEEP_BIT)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (strb.ctrl),
    .wdata_i   (wdata_i),
    .ctrl_rd_o (ctrl_rd),
    .irq_o     (iop_irq_o),
    .iopr_o    (iop_rst_o)
  );

  assign ctrl_keep = ctrl_rd[KEEP_BIT];

  always_comb begin
    rdata_o = '0;
    for (int unsigned i = 0; i < NUM_DATA; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = data_q[i];
    if (addr_i == ADDR_W'(SET_IDX) || addr_i == ADDR_W'(CLR_IDX)) rdata_o = flag_q;
    if (addr_i == ADDR_W'(CTRL_IDX)) rdata_o = ctrl_rd;
  end
endmodule

// File: rtl/ipc_mailbox_regs_chk.sv
module ipc_mailbox_regs_chk #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CTRL_A = 4,
  parameter int unsigned SET_A  = 2,
  parameter int unsigned CLR_A  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       flag_q,
  input logic              ctrl_keep,
  input logic              iop_irq_o,
  input logic              iop_rst_o
);
  logic w_ctrl, w_set, w_clr;
  assign w_ctrl = wr_en_i && (addr_i == ADDR_W'(CTRL_A));
  assign w_set  = wr_en_i && (addr_i == ADDR_W'(SET_A));
  assign w_clr  = wr_en_i && (addr_i == ADDR_W'(CLR_A));

  AST_SET_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_set |=> flag_q == ($past(flag_q) | $past(wdata_i))); // R2
  AST_CLR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_clr |=> flag_q == ($past(flag_q) & ~$past(wdata_i))); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_set || w_clr) |=> $stable(flag_q)); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_ctrl && wdata_i[18]) |=> iop_irq_o); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_ctrl && wdata_i[18]) |=> !iop_irq_o); // R5
  AST_IOPR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_ctrl && wdata_i[19]) |=> iop_rst_o); // R6
  AST_IOPR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_ctrl && wdata_i[19]) |=> !iop_rst_o); // R6
  AST_KEEP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_ctrl |=> ctrl_keep == $past(wdata_i[8])); // R7

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!iop_irq_o && !iop_rst_o && flag_q == '0); // R8
    end
  end
endmodule

bind ipc_mailbox_regs ipc_mailbox_regs_chk #(
  .ADDR_W(ADDR_W), .CTRL_A(CTRL_IDX), .SET_A(SET_IDX), .CLR_A(CLR_IDX)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .flag_q    (flag_q),
  .ctrl_keep (ctrl_keep),
  .iop_irq_o (iop_irq_o),
  .iop_rst_o (iop_rst_o)
);

// File: tb/ipc_mailbox_regs_bench.sv
module ipc_mailbox_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        iop_irq_o, iop_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_data [2];
  logic [31:0] m_flag;
  logic        m_keep;

  always #5 clk_i = ~clk_i;

  ipc_mailbox_regs u_ipc_mailbox_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .iop_irq_o(iop_irq_o), .iop_rst_o(iop_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input int a);
    case (a)
      0, 1:    return m_data[a];
      2, 3:    return m_flag;
      4:       return 32'(m_keep) << 8;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 1:    return "R1 data";
      2, 3:    return "R4 flag read";
      4:       return "R7 ctrl read";
      default: return "R9 unmapped";
    endcase
  endfunction

  // read every address through the port (wr_en low)
  task automatic read_all(input string ctx);
    for (int a = 0; a < 8; a++) begin
      addr_i = 3'(a);
      #1;
      chk({ctx, " ", tag_of(a)}, rdata_o, model_rd(a));
    end
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    bit irq_e, rst_e;
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'(a); wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    irq_e = (a == 4) && d[18];
    rst_e = (a == 4) && d[19];
    case (a)
      0, 1: m_data[a] = d;
      2:    m_flag = m_flag | d;
      3:    m_flag = m_flag & ~d;
      4:    m_keep = d[8];
      default: ;
    endcase
    chk("R5 irq pulse", 32'(iop_irq_o), 32'(irq_e));
    chk("R6 rst pulse", 32'(iop_rst_o), 32'(rst_e));
    read_all(a == 2 ? "R2" : a == 3 ? "R3" : "wr");
    @(negedge clk_i);
    chk("R5 irq one cycle", 32'(iop_irq_o), 32'h0);
    chk("R6 rst one cycle", 32'(iop_rst_o), 32'h0);
  endtask

  initial begin
    logic [31:0] x;
    m_data[0] = '0; m_data[1] = '0; m_flag = '0; m_keep = 1'b0;
    repeat (3) @(negedge clk_i);
    read_all("R8 reset");
    chk("R8 irq in reset", 32'(iop_irq_o), 32'h0);
    rst_ni = 1'b1;

    // directed corners
    do_write(2, 32'hF0F0_00FF);
    do_write(2, 32'h0F00_0100);          // R2 merge keeps old bits
    do_write(3, 32'h0000_00F0);          // R3 clears only ones
    do_write(4, 32'h000C_0100);          // R5 R6 together, R7 keep=1
    do_write(4, 32'h0004_0000);          // R5 only, R7 keep->0
    do_write(4, 32'h0008_0100);          // R6 only
    do_write(5, 32'hFFFF_FFFF);          // R9
    do_write(7, 32'h000C_0100);          // R9 no pulse
    do_write(0, 32'hDEAD_BEEF);
    do_write(1, 32'h1234_5678);

    // back-to-back control writes: pulse on each
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'd4; wdata_i = 32'h0004_0000;
    @(negedge clk_i);
    chk("R5 first b2b", 32'(iop_irq_o), 32'h1);
    wdata_i = 32'h0008_0000;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R5 second b2b irq low", 32'(iop_irq_o), 32'h0);
    chk("R6 second b2b", 32'(iop_rst_o), 32'h1);
    m_keep = 1'b0;
    @(negedge clk_i);

    // sweep
    x = 32'h1357_9BDF;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      x = x * 32'd1664525 + 32'd1013904223;
      d = x ^ {x[15:0], x[31:16]};
      do_write(int'(x[30:28]), d);
    end

    // reset: writes ignored while held
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_data[0] = '0; m_data[1] = '0; m_flag = '0; m_keep = 1'b0;
    wr_en_i = 1'b1; addr_i = 3'd4; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    chk("R8 irq held low", 32'(iop_irq_o), 32'h0);
    chk("R8 rst held low", 32'(iop_rst_o), 32'h0);
    addr_i = 3'd2;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    read_all("R8 after reset");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule